// File: doc/BRIEF.md
# Transceiver Reset Handshake Sequencer

This block brings the transmit and receive sides of a multi-lane serial transceiver out of reset. Each side has one reset request input that covers every lane and the datapath of that side, and each request is answered by an acknowledge. The handshake is four-phase: the acknowledge rises after the request rises and falls after the request falls. Once a side has left reset, the block collects a done strobe from every lane of that side. It raises that side's ready flag only when all strobes have arrived. On the receive side, every lane's clock-recovery lock must also be present.

When forward error correction is switched on, transmit bring-up has one more stage. After all transmit lanes are done, the block asks the user logic to start sending alignment markers. It waits until the user logic confirms that at least two markers have gone out, and then waits for that confirmation to fall again. Only then does transmit-ready rise. The transmit and receive sequences are independent state machines, so either side can be reset while the other keeps running.

Each state machine has five states. S_IDLE_RESET is held while the side's synchronised reset is high. S_WAIT_LANES collects lane done strobes, and on the receive side it also waits for lock. S_AM_REQ drives the marker request. S_AM_WAIT_DROP waits for the marker confirmation to return low. S_READY drives the ready flag.

The transitions are:
- S_IDLE_RESET to S_WAIT_LANES on the first clock after release.
- S_WAIT_LANES to S_READY when all lanes are done and lock is present. On the transmit side with correction on, the target is S_AM_REQ instead.
- S_AM_REQ to S_AM_WAIT_DROP when the synchronised confirmation is high.
- S_AM_WAIT_DROP to S_READY when the confirmation is low.
- S_READY to S_WAIT_LANES on loss of lock (receive side only).
- Any state to S_IDLE_RESET, asynchronously, when the side's reset asserts.

Top module: `xrs_xcvr_rst_seq`

## Requirements
- R1: While a reset request is held high, its acknowledge is high from the first rising clock edge after the request rose onward.
- R2: After a reset request falls, its acknowledge falls within SYNC_STAGES+1 rising edges and stays low while the request stays low.
- R3: A reset request released early, after spanning only one rising edge, still produces an acknowledge pulse, and the acknowledge then falls.
- R4: tx_ready stays low until every bit of tx_lane_done (bit i is lane i, a single-cycle pulse synchronous to clk) has pulsed at least once since the last transmit reset release. With fec_en low it then rises within two rising edges.
- R5: With fec_en high, am_start rises once all transmit lanes are done and stays high until am_sent_ack, after synchronisation, is seen high. tx_ready rises only after am_sent_ack has since been seen low again.
- R6: With fec_en low, am_start never asserts.
- R7: rx_ready rises only when every rx_lane_done bit has pulsed since the last receive reset release and every bit of rx_cdr_lock is high. Losing any lock drops rx_ready within SYNC_STAGES+1 edges. Regaining lock restores rx_ready without new done strobes.
- R8: Asserting a reset request drops that side's ready flag at once, without waiting for a clock edge. After release, fresh lane done strobes are needed before ready rises again.
- R9: Resetting one side leaves the other side's ready flag and acknowledge unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| tx_rst_req | input | 1 | Asynchronous transmit reset request, active high |
| rx_rst_req | input | 1 | Asynchronous receive reset request, active high |
| fec_en | input | 1 | Enables the alignment-marker stage; change only while transmit is in reset |
| tx_lane_done | input | LANES | Per-lane transmit reset-done pulses, synchronous to clk |
| rx_lane_done | input | LANES | Per-lane receive reset-done pulses, synchronous to clk |
| rx_cdr_lock | input | LANES | Asynchronous per-lane clock-recovery lock |
| am_sent_ack | input | 1 | Asynchronous confirmation that at least two markers were sent |
| tx_rst_ack | output | 1 | Transmit reset acknowledge |
| rx_rst_ack | output | 1 | Receive reset acknowledge |
| tx_ready | output | 1 | Transmit side ready for data |
| rx_ready | output | 1 | Receive side ready for data |
| am_start | output | 1 | Request to start emitting alignment markers |

## Verification
Transmit bring-up is repeated with the lane done pulses arriving in a random order with random gaps, and with fec_en drawn at random each time. This shows whether ready waits for the last lane and whether the marker stage is inserted only when correction is on. Directed cases cover the following:
- A reset pulse released after one edge, which tells the acknowledge pulse apart from plain level-following.
- A lock dropped on one random lane and then restored, which shows the lock gating on receive readiness.
- A restart with no new strobes, which shows that done history is cleared on reset.
- A transmit reset while receive is ready, which shows the two sides are independent.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [2:0] {
        S_IDLE_RESET   = 3'd0,
        S_WAIT_LANES   = 3'd1,
        S_AM_REQ       = 3'd2,
        S_AM_WAIT_DROP = 3'd3,
        S_READY        = 3'd4
    } seq_state_e;

endpackage

// File: rtl/xrs_rst_sync.sv
// Reset synchroniser: asserts asynchronously, releases after STAGES clock edges.
module xrs_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic req_async,
    output logic rst_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or posedge req_async) begin
        if (req_async) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b0};
        end
    end

    assign rst_sync = chain_q[STAGES-1];
endmodule

// File: rtl/xrs_bit_sync.sv
// Plain multi-stage level synchroniser for quasi-static inputs.
module xrs_bit_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        stg_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stg_q[s] <= stg_q[s-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/xrs_path_seq.sv
// One direction's bring-up sequencer. The marker stage exists only when HAS_AM is set.
module xrs_path_seq
    import xrs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter bit HAS_AM = 1'b1
) (
    input  logic             clk,
    input  logic             rst_s,
    input  logic [LANES-1:0] lane_done,
    input  logic             lock_ok,
    input  logic             fec_en,
    input  logic             am_ack_s,
    output logic             rst_ack,
    output logic             ready,
    output logic             am_start
);
    seq_state_e       state_q;
    seq_state_e       state_d;
    logic [LANES-1:0] done_q;
    logic             all_done;
    logic             use_am;

    // Lane done history, cleared by reset.
    always_ff @(posedge clk or posedge rst_s) begin
        if (rst_s) begin
            done_q <= '0;
        end else begin
            done_q <= done_q | lane_done;
        end
    end

    assign all_done = &done_q;

    if (HAS_AM) begin : g_am
        assign use_am = fec_en;
    end else begin : g_no_am
        assign use_am = 1'b0;
    end

    // Acknowledge follows the synchronised reset one edge later.
    always_ff @(posedge clk) begin
        rst_ack <= rst_s;
    end

    // State register.
    always_ff @(posedge clk or posedge rst_s) begin
        if (rst_s) begin
            state_q <= S_IDLE_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE_RESET: begin
                state_d = S_WAIT_LANES;
            end
            S_WAIT_LANES: begin
                if (all_done && lock_ok) begin
                    state_d = use_am ? S_AM_REQ : S_READY;
                end
            end
            S_AM_REQ: begin
                if (am_ack_s) begin
                    state_d = S_AM_WAIT_DROP;
                end
            end
            S_AM_WAIT_DROP: begin
                if (!am_ack_s) begin
                    state_d = S_READY;
                end
            end
            S_READY: begin
                if (!lock_ok) begin
                    state_d = S_WAIT_LANES;
                end
            end
            default: begin
                state_d = S_IDLE_RESET;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        ready    = 1'b0;
        am_start = 1'b0;
        unique case (state_q)
            S_READY:  ready    = 1'b1;
            S_AM_REQ: am_start = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/xrs_xcvr_rst_seq.sv
module xrs_xcvr_rst_seq #(
    parameter int LANES       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             tx_rst_req,
    input  logic             rx_rst_req,
    input  logic             fec_en,
    input  logic [LANES-1:0] tx_lane_done,
    input  logic [LANES-1:0] rx_lane_done,
    input  logic [LANES-1:0] rx_cdr_lock,
    input  logic             am_sent_ack,
    output logic             tx_rst_ack,
    output logic             rx_rst_ack,
    output logic             tx_ready,
    output logic             rx_ready,
    output logic             am_start
);
    logic             tx_rst_s;
    logic             rx_rst_s;
    logic [LANES-1:0] lock_s;
    logic             am_ack_s;
    logic             tx_am;
    logic             rx_am;

    xrs_rst_sync #(.STAGES(SYNC_STAGES)) u_tx_rst_sync (
        .clk       (clk),
        .req_async (tx_rst_req),
        .rst_sync  (tx_rst_s)
    );

    xrs_rst_sync #(.STAGES(SYNC_STAGES)) u_rx_rst_sync (
        .clk       (clk),
        .req_async (rx_rst_req),
        .rst_sync  (rx_rst_s)
    );

    xrs_bit_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) u_lock_sync (
        .clk (clk),
        .d   (rx_cdr_lock),
        .q   (lock_s)
    );

    xrs_bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .d   (am_sent_ack),
        .q   (am_ack_s)
    );

    xrs_path_seq #(.LANES(LANES), .HAS_AM(1'b1)) u_tx_seq (
        .clk       (clk),
        .rst_s     (tx_rst_s),
        .lane_done (tx_lane_done),
        .lock_ok   (1'b1),
        .fec_en    (fec_en),
        .am_ack_s  (am_ack_s),
        .rst_ack   (tx_rst_ack),
        .ready     (tx_ready),
        .am_start  (tx_am)
    );

    xrs_path_seq #(.LANES(LANES), .HAS_AM(1'b0)) u_rx_seq (
        .clk       (clk),
        .rst_s     (rx_rst_s),
        .lane_done (rx_lane_done),
        .lock_ok   (&lock_s),
        .fec_en    (1'b0),
        .am_ack_s  (1'b0),
        .rst_ack   (rx_rst_ack),
        .ready     (rx_ready),
        .am_start  (rx_am)
    );

    // The receive instance has its marker stage generated away, so rx_am is constant low.
    assign am_start = tx_am | rx_am;
endmodule

// File: rtl/xrs_seq_chk.sv
module xrs_seq_chk #(
    parameter int LANES       = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             tx_rst_req,
    input logic             rx_rst_req,
    input logic             fec_en,
    input logic [LANES-1:0] tx_lane_done,
    input logic [LANES-1:0] rx_lane_done,
    input logic [LANES-1:0] rx_cdr_lock,
    input logic             am_sent_ack,
    input logic             tx_rst_ack,
    input logic             rx_rst_ack,
    input logic             tx_ready,
    input logic             rx_ready,
    input logic             am_start
);
    localparam int CW = $clog2(SYNC_STAGES + 3) + 1;

    logic          seen_tx = 1'b0;
    logic          seen_rx = 1'b0;
    logic [CW-1:0] nolock_cnt = '0;

    always_ff @(posedge clk) begin
        if (tx_rst_req) seen_tx <= 1'b1;
        if (rx_rst_req) seen_rx <= 1'b1;
        if (&rx_cdr_lock) begin
            nolock_cnt <= '0;
        end else if (nolock_cnt < CW'(SYNC_STAGES + 2)) begin
            nolock_cnt <= nolock_cnt + 1'b1;
        end
    end

    a_r1_tx_ack_held: assert property (@(posedge clk) disable iff (!seen_tx)
        tx_rst_req && $past(tx_rst_req) |-> tx_rst_ack);

    a_r1_rx_ack_held: assert property (@(posedge clk) disable iff (!seen_rx)
        rx_rst_req && $past(rx_rst_req) |-> rx_rst_ack);

    a_r2_tx_ack_stays_low: assert property (@(posedge clk) disable iff (!seen_tx)
        !tx_rst_req && !$past(tx_rst_req) && !$past(tx_rst_ack) |-> !tx_rst_ack);

    a_r2_rx_ack_stays_low: assert property (@(posedge clk) disable iff (!seen_rx)
        !rx_rst_req && !$past(rx_rst_req) && !$past(rx_rst_ack) |-> !rx_rst_ack);

    a_r5_am_clears_after_ack: assert property (@(posedge clk) disable iff (!seen_tx || tx_rst_req)
        $fell(am_start) |-> $past(am_sent_ack, SYNC_STAGES + 1));

    a_r5_ready_after_ack_low: assert property (@(posedge clk) disable iff (!seen_tx || tx_rst_req)
        $rose(tx_ready) && fec_en |-> !$past(am_sent_ack, SYNC_STAGES + 1));

    a_r6_no_am_without_fec: assert property (@(posedge clk) disable iff (!seen_tx || tx_rst_req)
        !fec_en && $past(!fec_en) |-> !am_start);

    a_r7_lock_loss_drops_ready: assert property (@(posedge clk) disable iff (!seen_rx || rx_rst_req)
        nolock_cnt >= CW'(SYNC_STAGES + 1) |-> !rx_ready);

    a_r8_tx_reset_drops_ready: assert property (@(posedge clk) disable iff (!seen_tx)
        tx_rst_req |-> !tx_ready);

    a_r8_rx_reset_drops_ready: assert property (@(posedge clk) disable iff (!seen_rx)
        rx_rst_req |-> !rx_ready);
endmodule

bind xrs_xcvr_rst_seq xrs_seq_chk #(.LANES(LANES), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/test_xrs_xcvr_rst_seq.sv
module test_xrs_xcvr_rst_seq;
    localparam int LANES = 4;
    localparam int SYNC  = 2;

    logic             clk = 1'b0;
    logic             tx_rst_req = 1'b0;
    logic             rx_rst_req = 1'b0;
    logic             fec_en = 1'b0;
    logic [LANES-1:0] tx_lane_done = '0;
    logic [LANES-1:0] rx_lane_done = '0;
    logic [LANES-1:0] rx_cdr_lock = '0;
    logic             am_sent_ack = 1'b0;
    logic             tx_rst_ack, rx_rst_ack, tx_ready, rx_ready, am_start;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    xrs_xcvr_rst_seq #(.LANES(LANES), .SYNC_STAGES(SYNC)) i_xrs_xcvr_rst_seq (
        .clk          (clk),
        .tx_rst_req   (tx_rst_req),
        .rx_rst_req   (rx_rst_req),
        .fec_en       (fec_en),
        .tx_lane_done (tx_lane_done),
        .rx_lane_done (rx_lane_done),
        .rx_cdr_lock  (rx_cdr_lock),
        .am_sent_ack  (am_sent_ack),
        .tx_rst_ack   (tx_rst_ack),
        .rx_rst_ack   (rx_rst_ack),
        .tx_ready     (tx_ready),
        .rx_ready     (rx_ready),
        .am_start     (am_start)
    );

    function automatic logic exp_tx_ready(bit lanes_done, bit fec, bit am_done);
        return lanes_done && (!fec || am_done);
    endfunction

    function automatic logic exp_am(bit lanes_done, bit fec, bit ack_seen);
        return lanes_done && fec && !ack_seen;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tx_bringup(bit fec);
        int order [LANES];
        tx_rst_req = 1'b1;
        #2 check("R8 tx_ready drops at once", tx_ready, 1'b0);
        tick(2);
        check("R1 tx_rst_ack high", tx_rst_ack, 1'b1);
        check("R9 rx_ready unaffected", rx_ready, rx_cdr_lock == '1 ? 1'b1 : 1'b0);
        fec_en = fec;
        tx_rst_req = 1'b0;
        tick(SYNC + 2);
        check("R2 tx_rst_ack low", tx_rst_ack, 1'b0);
        for (int i = 0; i < LANES; i++) order[i] = i;
        for (int i = LANES - 1; i > 0; i--) begin
            int j = $urandom_range(0, i);
            int t = order[i];
            order[i] = order[j];
            order[j] = t;
        end
        for (int k = 0; k < LANES; k++) begin
            if (k == LANES - 1) begin
                check("R4 tx_ready waits for last lane", tx_ready, exp_tx_ready(1'b0, fec, 1'b0));
            end
            tx_lane_done[order[k]] = 1'b1;
            tick(1);
            tx_lane_done = '0;
            tick($urandom_range(0, 2));
        end
        tick(3);
        check("R4 tx_ready after lanes", tx_ready, exp_tx_ready(1'b1, fec, 1'b0));
        check(fec ? "R5 am_start requested" : "R6 am_start idle", am_start, exp_am(1'b1, fec, 1'b0));
        if (fec) begin
            am_sent_ack = 1'b1;
            tick(SYNC + 2);
            check("R5 am_start cleared", am_start, exp_am(1'b1, 1'b1, 1'b1));
            check("R5 tx_ready withheld while ack high", tx_ready, exp_tx_ready(1'b1, 1'b1, 1'b0));
            am_sent_ack = 1'b0;
            tick(SYNC + 2);
            check("R5 tx_ready after ack low", tx_ready, exp_tx_ready(1'b1, 1'b1, 1'b1));
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0a17));
        #1;
        tx_rst_req = 1'b1;
        rx_rst_req = 1'b1;
        tick(3);
        check("R1 reset state tx_rst_ack", tx_rst_ack, 1'b1);
        check("R1 reset state rx_rst_ack", rx_rst_ack, 1'b1);
        check("R8 reset state tx_ready", tx_ready, 1'b0);
        check("R8 reset state rx_ready", rx_ready, 1'b0);
        check("R6 reset state am_start", am_start, 1'b0);

        // Receive bring-up with lock gating.
        rx_rst_req = 1'b0;
        tick(SYNC + 2);
        check("R2 rx_rst_ack low", rx_rst_ack, 1'b0);
        rx_lane_done = '1;
        tick(1);
        rx_lane_done = '0;
        tick(5);
        check("R7 rx_ready needs lock", rx_ready, 1'b0);
        rx_cdr_lock = '1;
        tick(SYNC + 2);
        check("R7 rx_ready with lock", rx_ready, 1'b1);
        rx_cdr_lock[$urandom_range(0, LANES - 1)] = 1'b0;
        tick(SYNC + 2);
        check("R7 rx_ready drops on lock loss", rx_ready, 1'b0);
        rx_cdr_lock = '1;
        tick(SYNC + 2);
        check("R7 rx_ready back on relock", rx_ready, 1'b1);

        // Transmit bring-ups: directed both modes, then random.
        tx_bringup(1'b0);
        tx_bringup(1'b1);
        for (int it = 0; it < 12; it++) begin
            tx_bringup(1'($urandom_range(0, 1)));
        end
        check("R9 rx_rst_ack unaffected", rx_rst_ack, 1'b0);

        // Restart without new strobes: ready must stay low.
        tx_rst_req = 1'b1;
        fec_en = 1'b0;
        tick(2);
        tx_rst_req = 1'b0;
        tick(8);
        check("R8 restart needs fresh strobes", tx_ready, 1'b0);

        // Early-released reset pulse spanning one rising edge.
        tx_rst_req = 1'b1;
        #11 tx_rst_req = 1'b0;
        tick(1);
        check("R3 short pulse acknowledged", tx_rst_ack, 1'b1);
        tick(4);
        check("R3 ack follows release", tx_rst_ack, 1'b0);

        // Receive reset while transmit is up.
        tx_lane_done = '1;
        tick(1);
        tx_lane_done = '0;
        tick(3);
        check("R4 tx_ready after all lanes", tx_ready, 1'b1);
        rx_rst_req = 1'b1;
        #2 check("R8 rx_ready drops at once", rx_ready, 1'b0);
        tick(3);
        check("R9 tx_ready unaffected", tx_ready, 1'b1);
        check("R9 tx_rst_ack unaffected", tx_rst_ack, 1'b0);
        rx_rst_req = 1'b0;
        tick(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule